// File: doc/BRIEF.md
# Ring Event Interrupt Status Bank

This block collects per-channel completion events from a DMA ring engine and presents them to software as packed clear-on-read status words. Each channel contributes three event classes: transmit done, receive done and receive overflow. The three classes sit back to back in one flat bit vector. That vector is cut into as many 32-bit status words as it needs, so the status word count depends on the channel count.

A matching bank of per-channel enable bits selects which events may raise the single interrupt output. After the interrupt fires, the bank is disarmed. It re-arms only once software has read every status word at least once, including words whose channels are all disabled. An optional auto-clear mode drops the interrupt output on the first status read, but re-arming still needs the full sweep.

The register port is a plain request/response bus. A read or write request is accepted in the cycle it is presented, so there is no back-pressure. Read data returns one cycle later, qualified by `reg_rvalid`. Event inputs are single-cycle pulses and are always accepted.

Top module: `ring_irq_status`

## Requirements
- R1: With NCH channels, NST = (31 + 3*NCH)/32 status words sit at word addresses 0..NST-1. Word k returns bits 32k+31..32k of a flat vector in which transmit-done of channel i is bit i, receive-done is bit NCH+i and receive-overflow is bit 2*NCH+i. Bits at or above 3*NCH read as zero.
- R2: Reading a status word returns its current value and clears it. Data and `reg_rvalid` appear the cycle after the request.
- R3: An event arriving in the same cycle as a read of its word is not in that read's data. It is kept, and it appears in the next read.
- R4: Enable words (NEN = (31 + 2*NCH)/32) sit at 0x10+k and are read/write. Receive of channel i is bit i and transmit is bit NCH+i. Bits at or above 2*NCH read as zero. Overflow events use their channel's receive enable.
- R5: Address 0x20 is read-only and returns the channel count in bits 10:0.
- R6: Address 0x21 is read/write. Bit 2 selects auto-clear mode, and that bit reads back.
- R7: While armed, an event whose enable bit is set raises `irq` in the cycle after the event. An event with its enable bit clear does not raise `irq`.
- R8: Outside auto-clear mode, `irq` stays high until every status word has been read since it rose. The read that completes the set drops `irq` and re-arms the bank.
- R9: In auto-clear mode, any status read drops `irq`. Re-arming still needs every status word to be read.
- R10: While disarmed, events still latch into status but do not raise `irq`.
- R11: After reset, status, enables and the mode bit are zero, `irq` and `reg_rvalid` are low, and the bank is armed.
- R12: `reg_rvalid` is high exactly in the cycle after each read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | NCH | Per-channel transmit-done pulses |
| rx_done | input | NCH | Per-channel receive-done pulses |
| rx_ovf | input | NCH | Per-channel receive-overflow pulses |
| reg_rd | input | 1 | Read request |
| reg_wr | input | 1 | Write request |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response strobe |
| irq | output | 1 | Interrupt output |

## Verification
A wrong arm state or a stale read-sweep record shows at `irq`. An interrupt that fires while it should be held off appears the cycle after the offending event. An interrupt that stays high after the final status read is visible one cycle after that read. A misplaced or lost status bit is only seen at the next read of its word, so each event in the tests is followed by reads of every word. A status word that does not clear appears as a nonzero value on an immediate repeat read.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] EN_BASE   = 6'h10;
  localparam logic [ADDR_W-1:0] CAP_ADDR  = 6'h20;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 6'h21;
  localparam int AUTO_BIT = 2;

  function automatic int words_for(input int bits_per_ch, input int nch);
    return (31 + bits_per_ch * nch) / 32;
  endfunction
endpackage

// File: rtl/ring_evt_status.sv
module ring_evt_status
  import ring_irq_pkg::*;
#(
  parameter int NCH = 12,
  parameter int NST = words_for(3, NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3*NCH-1:0]      set_flat,
  input  logic [NST-1:0]        clr_vec,
  output logic [NST*WORD_W-1:0] stat_flat
);
  localparam int FLAT_W = NST * WORD_W;
  localparam int EV_W   = 3 * NCH;

  logic [FLAT_W-1:0] set_pad;

  always_comb begin
    set_pad = '0;
    set_pad[EV_W-1:0] = set_flat;
  end

  for (genvar k = 0; k < NST; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_flat[k*WORD_W +: WORD_W] <= '0;
      end else begin
        stat_flat[k*WORD_W +: WORD_W] <=
          (clr_vec[k] ? '0 : stat_flat[k*WORD_W +: WORD_W]) | set_pad[k*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/ring_en_regs.sv
module ring_en_regs
  import ring_irq_pkg::*;
#(
  parameter int NCH = 12,
  parameter int NEN = words_for(2, NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NEN-1:0]        wr_vec,
  input  logic [WORD_W-1:0]     wdata,
  output logic [NEN*WORD_W-1:0] en_flat
);
  localparam int ENW = NEN * WORD_W;
  localparam logic [ENW-1:0] LIVE = ENW'({(2*NCH){1'b1}});

  for (genvar k = 0; k < NEN; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_flat[k*WORD_W +: WORD_W] <= '0;
      end else if (wr_vec[k]) begin
        en_flat[k*WORD_W +: WORD_W] <= wdata & LIVE[k*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/ring_irq_arm.sv
module ring_irq_arm #(
  parameter int NST = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           auto_clr,
  input  logic [NST-1:0] rd_vec,
  input  logic           hit,
  output logic           irq
);
  logic           armed;
  logic [NST-1:0] seen;
  logic [NST-1:0] seen_nx;
  logic           any_rd;
  logic           fire;

  assign seen_nx = seen | rd_vec;
  assign any_rd  = |rd_vec;
  assign fire    = armed & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
      irq   <= 1'b0;
      seen  <= '0;
    end else if (fire) begin
      armed <= 1'b0;
      irq   <= 1'b1;
      seen  <= '0;
    end else begin
      if (!armed) begin
        if (any_rd && (&seen_nx)) begin
          armed <= 1'b1;
          irq   <= 1'b0;
          seen  <= '0;
        end else begin
          seen  <= seen_nx;
        end
      end
      if (auto_clr && any_rd) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_irq_status.sv
module ring_irq_status
  import ring_irq_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tx_done,
  input  logic [NCH-1:0]    rx_done,
  input  logic [NCH-1:0]    rx_ovf,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              irq
);
  localparam int NST  = words_for(3, NCH);
  localparam int NEN  = words_for(2, NCH);
  localparam int EV_W = 3 * NCH;

  logic [EV_W-1:0]        set_flat;
  logic [EV_W-1:0]        en_map;
  logic [NST-1:0]         rd_vec;
  logic [NEN-1:0]         wr_vec;
  logic [NST*WORD_W-1:0]  stat_flat;
  logic [NEN*WORD_W-1:0]  en_flat;
  logic                   auto_q;
  logic [WORD_W-1:0]      rd_mux;

  assign set_flat = {rx_ovf, rx_done, tx_done};

  for (genvar i = 0; i < NCH; i++) begin : g_map
    assign en_map[i]         = en_flat[NCH + i];
    assign en_map[NCH + i]   = en_flat[i];
    assign en_map[2*NCH + i] = en_flat[i];
  end

  for (genvar k = 0; k < NST; k++) begin : g_rdec
    assign rd_vec[k] = reg_rd && (reg_addr == ADDR_W'(k));
  end

  for (genvar k = 0; k < NEN; k++) begin : g_wdec
    assign wr_vec[k] = reg_wr && (reg_addr == EN_BASE + ADDR_W'(k));
  end

  ring_evt_status #(.NCH(NCH), .NST(NST)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_flat  (set_flat),
    .clr_vec   (rd_vec),
    .stat_flat (stat_flat)
  );

  ring_en_regs #(.NCH(NCH), .NEN(NEN)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_vec  (wr_vec),
    .wdata   (reg_wdata),
    .en_flat (en_flat)
  );

  ring_irq_arm #(.NST(NST)) u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .auto_clr (auto_q),
    .rd_vec   (rd_vec),
    .hit      (|(set_flat & en_map)),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
    end else if (reg_wr && reg_addr == MODE_ADDR) begin
      auto_q <= reg_wdata[AUTO_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NST; k++) begin
      if (reg_addr == ADDR_W'(k)) rd_mux = stat_flat[k*WORD_W +: WORD_W];
    end
    for (int k = 0; k < NEN; k++) begin
      if (reg_addr == EN_BASE + ADDR_W'(k)) rd_mux = en_flat[k*WORD_W +: WORD_W];
    end
    if (reg_addr == CAP_ADDR)  rd_mux = WORD_W'(11'(NCH));
    if (reg_addr == MODE_ADDR) rd_mux = WORD_W'({auto_q, 2'b00});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ring_irq_status_chk.sv
module ring_irq_status_chk
  import ring_irq_pkg::*;
#(
  parameter int NCH = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    tx_done,
  input logic [NCH-1:0]    rx_done,
  input logic [NCH-1:0]    rx_ovf,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              reg_rvalid,
  input logic              irq
);
  // R12
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R12
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R5
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == CAP_ADDR) |=> (reg_rdata[10:0] == 11'(NCH)));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|{tx_done, rx_done, rx_ovf}));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_rd) |=> irq);
endmodule

bind ring_irq_status ring_irq_status_chk #(.NCH(NCH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_done    (tx_done),
  .rx_done    (rx_done),
  .rx_ovf     (rx_ovf),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .irq        (irq)
);

// File: tb/ring_irq_status_tb_top.sv
module ring_irq_status_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH   = 12;
  localparam int EVW   = 3 * NCH;
  localparam logic [1:0] OP_EV = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]     op;
    logic [5:0]     addr;
    logic [EVW-1:0] ev;
    logic [31:0]    data;
    logic           irq;
    logic [3:0]     req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 6'h20, 36'h0,         32'h0000000C, 1'b0, 4'd5},  // R5 capability
    '{OP_WR, 6'h10, 36'h0,         32'h00FFFFFF, 1'b0, 4'd4},  // R4 enable all
    '{OP_RD, 6'h10, 36'h0,         32'h00FFFFFF, 1'b0, 4'd4},  // R4 readback
    '{OP_EV, 6'h00, 36'h000000001, 32'h0,        1'b1, 4'd7},  // R7 tx ch0 fires
    '{OP_RD, 6'h00, 36'h0,         32'h00000001, 1'b1, 4'd8},  // R8 held
    '{OP_RD, 6'h00, 36'h0,         32'h00000000, 1'b1, 4'd2},  // R2 cleared
    '{OP_RD, 6'h01, 36'h0,         32'h00000000, 1'b0, 4'd8},  // R8 sweep done
    '{OP_EV, 6'h00, 36'h200000000, 32'h0,        1'b1, 4'd1},  // R1 ovf ch9
    '{OP_RD, 6'h01, 36'h0,         32'h00000002, 1'b1, 4'd1},  // R1 word1 bit1
    '{OP_EV, 6'h00, 36'h000000008, 32'h0,        1'b1, 4'd10}, // R10 disarmed
    '{OP_RD, 6'h00, 36'h0,         32'h00000008, 1'b0, 4'd8},  // R8 rearm
    '{OP_WR, 6'h10, 36'h0,         32'h00000FFF, 1'b0, 4'd4},  // R4 rx only
    '{OP_EV, 6'h00, 36'h000000020, 32'h0,        1'b0, 4'd7},  // R7 disabled tx
    '{OP_RD, 6'h00, 36'h0,         32'h00000020, 1'b0, 4'd2},  // R2 latched
    '{OP_EV, 6'h00, 36'h000004000, 32'h0,        1'b1, 4'd7},  // R7 rx ch2
    '{OP_WR, 6'h21, 36'h0,         32'h00000004, 1'b1, 4'd6},  // R6 auto on
    '{OP_RD, 6'h01, 36'h0,         32'h00000000, 1'b0, 4'd9},  // R9 any read
    '{OP_EV, 6'h00, 36'h000002000, 32'h0,        1'b0, 4'd10}, // R10 disarmed
    '{OP_RD, 6'h21, 36'h0,         32'h00000004, 1'b0, 4'd6},  // R6 readback
    '{OP_RD, 6'h00, 36'h0,         32'h00006000, 1'b0, 4'd9},  // R9 rearm
    '{OP_EV, 6'h00, 36'h000010000, 32'h0,        1'b1, 4'd9},  // R9 fires
    '{OP_RD, 6'h00, 36'h0,         32'h00010000, 1'b0, 4'd9}   // R9 auto drop
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] tx_done = '0, rx_done = '0, rx_ovf = '0;
  logic           reg_rd = 1'b0, reg_wr = 1'b0;
  logic [5:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           reg_rvalid;
  logic           irq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ring_irq_status #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .rx_done(rx_done),
    .rx_ovf(rx_ovf), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic rd, input logic wr, input logic [5:0] a,
                     input logic [31:0] d, input logic [EVW-1:0] ev);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    tx_done = ev[NCH-1:0]; rx_done = ev[2*NCH-1:NCH]; rx_ovf = ev[3*NCH-1:2*NCH];
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0;
    tx_done = '0; rx_done = '0; rx_ovf = '0;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 irq in reset", 32'(irq), 32'h0);
    check("R11 rvalid in reset", 32'(reg_rvalid), 32'h0);
    rst_n = 1'b1;
    run(1'b1, 1'b0, 6'h00, 32'h0, '0);
    check("R11 status after reset", reg_rdata, 32'h0);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v].op == OP_RD, VEC[v].op == OP_WR, VEC[v].addr, VEC[v].data, VEC[v].ev);
      checks++;
      if (irq !== VEC[v].irq) begin
        errors++;
        $display("FAIL R%0d vec %0d irq actual=%b expected=%b", VEC[v].req, v, irq, VEC[v].irq);
      end
      check("R12 rvalid", 32'(reg_rvalid), 32'(VEC[v].op == OP_RD));
      if (VEC[v].op == OP_RD) begin
        checks++;
        if (reg_rdata !== VEC[v].data) begin
          errors++;
          $display("FAIL R%0d vec %0d rdata actual=%h expected=%h", VEC[v].req, v, reg_rdata, VEC[v].data);
        end
      end
    end

    // R8: finish the sweep so the bank is armed again
    run(1'b1, 1'b0, 6'h01, 32'h0, '0);
    check("R8 word1 empty", reg_rdata, 32'h0);
    // R3: event in the same cycle as the read of its word
    run(1'b1, 1'b0, 6'h00, 32'h0, 36'h000000080);
    check("R3 same-cycle read data", reg_rdata, 32'h0);
    check("R7 disabled tx no irq", 32'(irq), 32'h0);
    run(1'b1, 1'b0, 6'h00, 32'h0, '0);
    check("R3 kept event", reg_rdata, 32'h00000080);
    // R4: overflow gated by receive enable
    run(1'b0, 1'b0, 6'h00, 32'h0, 36'hFFF000000);
    check("R4 ovf uses rx enable", 32'(irq), 32'h1);
    run(1'b1, 1'b0, 6'h01, 32'h0, '0);
    check("R1 unused bits zero", reg_rdata, 32'h0000000F);
    check("R9 auto drop", 32'(irq), 32'h0);
    run(1'b1, 1'b0, 6'h00, 32'h0, '0);
    check("R1 ovf in word0", reg_rdata, 32'hFF000000);
    run(1'b0, 1'b1, 6'h10, 32'hFFFFFFFF, '0);
    run(1'b1, 1'b0, 6'h10, 32'h0, '0);
    check("R4 enable upper bits zero", reg_rdata, 32'h00FFFFFF);

    // R11: reset mid-run
    run(1'b0, 1'b0, 6'h00, 32'h0, 36'h000000001);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 irq cleared by reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    run(1'b1, 1'b0, 6'h10, 32'h0, '0);
    check("R11 enables zero", reg_rdata, 32'h0);
    run(1'b1, 1'b0, 6'h21, 32'h0, '0);
    check("R11 mode zero", reg_rdata, 32'h0);
    run(1'b1, 1'b0, 6'h00, 32'h0, '0);
    check("R11 status zero", reg_rdata, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule